// File: doc/BRIEF.md
# E3 Receive Alarm Interrupt Controller

This block gathers the receive-side alarm and framing events of an E3 framer and reports them to a host. It has byte-wide enable and status registers and one active-low interrupt request line. The alarm detectors supply four condition levels: out of frame, loss of frame, loss of signal and alarm indication signal. The frame synchronizer gives a realignment pulse together with a flag. The flag tells whether sync came back at a different alignment. A frame strobe marks when the received A bit is valid.

Each source is turned into an event. A level source gives an event on any change, whether the condition rises or falls. The realignment source gives an event only when the alignment really moved. The far-end receive failure (FERF) state follows the A bit, and a change in that state gives an event whether the failure is being declared or cleared. An event that is enabled sets its status bit. The interrupt line stays low while any status bit is set. The host clears the status bits by reading them.

Top module: `e3_rx_alarm_irq`

## Requirements
- R1: After reset, all enable and status bits are 0, `irq_n_o` is 1 and `rdata_o` is 0.
- R2: Enable register A at 0x12 holds bit 4 = realignment, bit 3 = out of frame, bit 2 = loss of frame, bit 1 = loss of signal and bit 0 = AIS. Bits 7..5 ignore writes and read as 0. An address outside 0x12..0x15 reads as 0x00.
- R3: Enable register B at 0x13 keeps only bit 3, the FERF-change enable. Every other bit reads as 0.
- R4: Status register A at 0x14 uses the bit positions of R2. A change of the out-of-frame, loss-of-frame, loss-of-signal or AIS input, in either direction, sets the matching status bit at the next clock edge when that source is enabled.
- R5: A realignment pulse with the new-alignment flag at 1 sets status A bit 4 when it is enabled. A realignment pulse with the flag at 0 never sets it.
- R6: On a frame strobe, the FERF state takes the value of the A bit. A change of that state, whether 0 to 1 or 1 to 0, sets status register B (0x15) bit 3 when it is enabled. The A bit has no effect without a strobe.
- R7: An event whose enable bit is 0 leaves its status bit at 0.
- R8: A read drives `rdata_o` at the next edge and is 0x00 in cycles with no read. A read of a status register returns its value and clears it.
- R9: An event that arrives in the same cycle as a read of its status register is kept in the register and is returned by the next read.
- R10: `irq_n_o` is 0 exactly while at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oof_i | input | 1 | Out-of-frame level |
| lof_i | input | 1 | Loss-of-frame level |
| los_i | input | 1 | Loss-of-signal level |
| ais_i | input | 1 | AIS level |
| realign_i | input | 1 | Pulse: frame sync regained |
| realign_new_i | input | 1 | With `realign_i`: the alignment differs from the old one |
| frame_stb_i | input | 1 | Pulse: `a_bit_i` is valid for this frame |
| a_bit_i | input | 1 | Received A bit |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
The bench goes after these corner cases:
- **Realignment at the old position.** A design that keys on `realign_i` alone would report a false change of alignment.
- **A bit repeated, or sent without a strobe.** A FERF detector that is level-based or ignores the strobe would either miss the clearing edge or raise extra events.
- **Event in the same cycle as a status read.** A design that clears after setting would lose that event. The bench checks that the next read still returns it.
- **Disabled sources and the unused high bits.** A design that leaked either would show stray status bits, or `irq_n_o` going low with nothing to service.

// File: rtl/e3_rx_alarm_irq.sv
module e3_rx_alarm_irq #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] EN_A_ADDR = 'h12,
  parameter logic [ADDR_W-1:0] EN_B_ADDR = 'h13,
  parameter logic [ADDR_W-1:0] ST_A_ADDR = 'h14,
  parameter logic [ADDR_W-1:0] ST_B_ADDR = 'h15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oof_i,
  input  logic              lof_i,
  input  logic              los_i,
  input  logic              ais_i,
  input  logic              realign_i,
  input  logic              realign_new_i,
  input  logic              frame_stb_i,
  input  logic              a_bit_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_n_o
);
  localparam int NSRC = 5;

  logic [3:0]      lvl_q;
  logic            ferf_q;
  logic [NSRC-1:0] en_a_q, st_a_q;
  logic            en_b_q, st_b_q;
  logic [7:0]      rd_mux;

  wire [3:0]      lvl    = {oof_i, lof_i, los_i, ais_i};
  wire [NSRC-1:0] ev_a   = {realign_i & realign_new_i, lvl ^ lvl_q};
  wire            ev_b   = frame_stb_i & (a_bit_i ^ ferf_q);
  wire            rd_a   = rd_en_i && (addr_i == ST_A_ADDR);
  wire            rd_b   = rd_en_i && (addr_i == ST_B_ADDR);

  always_comb begin
    rd_mux = 8'h00;
    if (addr_i == EN_A_ADDR)      rd_mux[NSRC-1:0] = en_a_q;
    else if (addr_i == EN_B_ADDR) rd_mux[3]        = en_b_q;
    else if (addr_i == ST_A_ADDR) rd_mux[NSRC-1:0] = st_a_q;
    else if (addr_i == ST_B_ADDR) rd_mux[3]        = st_b_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      ferf_q  <= 1'b0;
      en_a_q  <= '0;
      en_b_q  <= 1'b0;
      st_a_q  <= '0;
      st_b_q  <= 1'b0;
      rdata_o <= 8'h00;
    end else begin
      lvl_q   <= lvl;
      if (frame_stb_i) ferf_q <= a_bit_i;
      if (wr_en_i && addr_i == EN_A_ADDR) en_a_q <= wdata_i[NSRC-1:0];
      if (wr_en_i && addr_i == EN_B_ADDR) en_b_q <= wdata_i[3];
      st_a_q  <= (rd_a ? '0 : st_a_q) | (ev_a & en_a_q);
      st_b_q  <= (rd_b ? 1'b0 : st_b_q) | (ev_b & en_b_q);
      rdata_o <= rd_en_i ? rd_mux : 8'h00;
    end
  end

  assign irq_n_o = ~(|st_a_q | st_b_q);
endmodule

module e3_rx_alarm_irq_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ST_A_ADDR = 'h14,
  parameter logic [ADDR_W-1:0] EN_A_ADDR = 'h12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              realign_i,
  input logic              realign_new_i,
  input logic              frame_stb_i,
  input logic              a_bit_i,
  input logic              ais_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        rdata_o,
  input logic              irq_n_o,
  input logic [4:0]        en_a_q,
  input logic [4:0]        st_a_q,
  input logic              en_b_q,
  input logic              st_b_q,
  input logic              ais_q,
  input logic              ferf_q
);
  // R5
  cofa_old_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (realign_i && !realign_new_i && !st_a_q[4]) |=> !st_a_q[4]);

  // R7
  oof_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_a_q[3] && !st_a_q[3]) |=> !st_a_q[3]);

  // R4
  ais_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a_q[0] && (ais_i != ais_q)) |=> st_a_q[0]);

  // R6
  ferf_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_b_q && frame_stb_i && (a_bit_i != ferf_q)) |=> st_b_q);

  // R8
  status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == ST_A_ADDR) |=> (rdata_o == {3'b000, $past(st_a_q)}));

  // R2
  unused_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == EN_A_ADDR) |=> (rdata_o[7:5] == 3'b000));

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n_o && !rd_en_i) |=> !irq_n_o);
endmodule

bind e3_rx_alarm_irq e3_rx_alarm_irq_chk #(
  .ADDR_W(ADDR_W), .ST_A_ADDR(ST_A_ADDR), .EN_A_ADDR(EN_A_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .realign_i(realign_i), .realign_new_i(realign_new_i),
  .frame_stb_i(frame_stb_i), .a_bit_i(a_bit_i), .ais_i(ais_i),
  .rd_en_i(rd_en_i), .addr_i(addr_i), .rdata_o(rdata_o), .irq_n_o(irq_n_o),
  .en_a_q(en_a_q), .st_a_q(st_a_q), .en_b_q(en_b_q), .st_b_q(st_b_q),
  .ais_q(lvl_q[0]), .ferf_q(ferf_q)
);

// File: tb/e3_rx_alarm_irq_tb.sv
module e3_rx_alarm_irq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic oof = 0, lof = 0, los = 0, ais = 0;
  logic realign = 0, realign_new = 0, stb = 0, abit = 0;
  logic wr = 0, rd = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic [7:0] rdata;
  logic irq_n;

  int total = 0, bad = 0;

  logic [4:0] m_en_a = 0, m_st_a = 0;
  logic       m_en_b = 0, m_st_b = 0, m_ferf = 0;
  logic [3:0] m_lvl = 0;
  logic [7:0] m_rdata = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  e3_rx_alarm_irq dut_i (
    .clk(clk), .rst_n(rst_n), .oof_i(oof), .lof_i(lof), .los_i(los), .ais_i(ais),
    .realign_i(realign), .realign_new_i(realign_new), .frame_stb_i(stb), .a_bit_i(abit),
    .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_n_o(irq_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] reg_val(input logic [7:0] a);
    case (a)
      8'h12:   return {3'b0, m_en_a};
      8'h13:   return {4'b0, m_en_b, 3'b0};
      8'h14:   return {3'b0, m_st_a};
      8'h15:   return {4'b0, m_st_b, 3'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_step();
    logic [4:0] ev_a;
    logic       ev_b;
    ev_a = {realign & realign_new, {oof, lof, los, ais} ^ m_lvl};
    ev_b = stb & (abit ^ m_ferf);
    m_rdata = rd ? reg_val(addr) : 8'h00;
    m_st_a  = ((rd && addr == 8'h14) ? 5'b0 : m_st_a) | (ev_a & m_en_a);
    m_st_b  = ((rd && addr == 8'h15) ? 1'b0 : m_st_b) | (ev_b & m_en_b);
    m_lvl   = {oof, lof, los, ais};
    if (stb) m_ferf = abit;
    if (wr && addr == 8'h12) m_en_a = wdata[4:0];
    if (wr && addr == 8'h13) m_en_b = wdata[3];
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    model_step();
    check(rdata == m_rdata, "R8", rdata, m_rdata);
    check(irq_n == ~(|m_st_a | m_st_b), "R10", irq_n, ~(|m_st_a | m_st_b));
    rd = 0; wr = 0; realign = 0; realign_new = 0; stb = 0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [7:0] v);
    rd = 1; addr = a;
    tick();
    v = rdata;
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
    wr = 1; addr = a; wdata = d;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1
    check(irq_n == 1, "R1", irq_n, 1);
    check(rdata == 0, "R1", rdata, 0);
    for (int a = 8'h12; a <= 8'h15; a++) begin
      reg_rd(a[7:0], v); check(v == 0, "R1", v, 0);
    end
    // R2 / R3
    reg_wr(8'h12, 8'hFF); reg_rd(8'h12, v); check(v == 8'h1F, "R2", v, 8'h1F);
    reg_wr(8'h13, 8'hFF); reg_rd(8'h13, v); check(v == 8'h08, "R3", v, 8'h08);
    reg_rd(8'h20, v); check(v == 8'h00, "R2", v, 0);
    // R5: realign at old alignment, then at a new one
    realign = 1; realign_new = 0; tick();
    reg_rd(8'h14, v); check(v == 8'h00, "R5", v, 0);
    realign = 1; realign_new = 1; tick();
    check(irq_n == 0, "R10", irq_n, 0);
    reg_rd(8'h14, v); check(v == 8'h10, "R5", v, 8'h10);
    check(irq_n == 1, "R10", irq_n, 1);
    // R4 / R8: LOS rise and fall
    los = 1; tick();
    reg_rd(8'h14, v); check(v == 8'h02, "R4", v, 8'h02);
    reg_rd(8'h14, v); check(v == 8'h00, "R8", v, 0);
    los = 0; tick();
    reg_rd(8'h14, v); check(v == 8'h02, "R4", v, 8'h02);
    // R6: FERF declare, repeat, strobe-less, clear
    abit = 1; stb = 1; tick();
    reg_rd(8'h15, v); check(v == 8'h08, "R6", v, 8'h08);
    abit = 1; stb = 1; tick();
    reg_rd(8'h15, v); check(v == 8'h00, "R6", v, 0);
    abit = 0; tick();
    reg_rd(8'h15, v); check(v == 8'h00, "R6", v, 0);
    abit = 0; stb = 1; tick();
    reg_rd(8'h15, v); check(v == 8'h08, "R6", v, 8'h08);
    // R9: event in the read cycle
    ais = 1; reg_rd(8'h14, v); check(v == 8'h00, "R9", v, 0);
    reg_rd(8'h14, v); check(v == 8'h01, "R9", v, 8'h01);
    // R7: all disabled
    reg_wr(8'h12, 8'h00); reg_wr(8'h13, 8'h00);
    oof = 1; lof = 1; ais = 0; realign = 1; realign_new = 1; tick();
    abit = 1; stb = 1; tick();
    check(irq_n == 1, "R7", irq_n, 1);
    reg_rd(8'h14, v); check(v == 8'h00, "R7", v, 0);
    reg_rd(8'h15, v); check(v == 8'h00, "R7", v, 0);

    // random phase
    void'($urandom(32'h5EED1));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) oof = ~oof;
      if ($urandom_range(7) == 0) lof = ~lof;
      if ($urandom_range(7) == 0) los = ~los;
      if ($urandom_range(7) == 0) ais = ~ais;
      realign = ($urandom_range(9) == 0);
      realign_new = $urandom_range(1);
      stb = ($urandom_range(3) == 0);
      abit = ($urandom_range(2) == 0);
      addr = 8'h10 + 8'($urandom_range(7));
      wdata = 8'($urandom);
      wr = ($urandom_range(11) == 0);
      rd = ($urandom_range(3) == 0);
      tick();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule